// File: doc/BRIEF.md
# Non-Maskable Trap Controller

This block sits in front of a processor's exception entry logic. It takes run-time error strobes from hardware sources and records each one in a dedicated flag bit. It then forces a jump to that source's fixed vector, which no enable can mask. Each hardware source belongs to one of several fixed priority classes. A new trap is taken only when its class ranks above every trap service already running. While any hardware trap service runs, the block holds an inhibit line that keeps ordinary and data-transfer interrupts out.

A software trap request carries an explicit trap number. It is queued in a one-deep slot and taken only when no service is running and no hardware trap is waiting. Its service is the lowest level, and any hardware trap may preempt it. Each service ends with a return strobe, which retires the innermost active level. Software clears flag bits by writing zeros.

Control is a three-state machine: `ST_IDLE` (no service), `ST_SOFT` (only a software trap service active) and `ST_HW` (at least one hardware trap service active). The transitions are:
- `ST_IDLE` goes to `ST_HW` on a hardware take, or to `ST_SOFT` on a software take.
- `ST_SOFT` goes to `ST_HW` on a hardware take, or to `ST_IDLE` on a return.
- `ST_HW` stays in `ST_HW` on a nested take, or on a return that leaves a hardware level active. It goes to `ST_SOFT` on a return that leaves only the software level. It goes to `ST_IDLE` on a return that leaves nothing.

Top module: `trap_unit`

## Requirements
- R1: After reset, `flags_o`, `take_o`, `vec_o` and `irq_inhibit_o` are all zero.
- R2: A one-cycle strobe on `err_i[i]` sets `flags_o[i]`, visible after the next rising clock edge.
- R3: A flag bit clears only on a write (`flag_wr_i`=1) whose `flag_wdata_i` bit is 0. Data bits of 1 leave flags unchanged. An error strobe in the same cycle as a clearing write leaves the bit set.
- R4: A hardware trap of source i produces a one-cycle `take_o` pulse two rising edges after the strobe is sampled, if it is allowed. `vec_o` then equals (HW_BASE+i)*4, which is (2+i)*4 by default.
- R5: The priority classes are fixed: with the defaults, sources 0–2 are class 2 (highest), sources 3–5 are class 1 and sources 6–7 are class 0. Among pending hardware traps, the lowest source index is taken first.
- R6: During a service of class c, a pending trap of a class above c is taken at once. A trap of class c or below waits until enough returns have lowered the active level.
- R7: `irq_inhibit_o` rises together with a hardware `take_o`. It stays high until the return strobe that ends the outermost hardware service.
- R8: A software request with number n is taken when no service is active and no hardware trap is pending, with `vec_o` = n*4. It does not raise `irq_inhibit_o`. While one request waits, further requests are ignored.
- R9: A sampled `svc_ret_i` retires the innermost active level. No trap is taken on that same edge.
- R10: A new strobe on a source whose flag is already set is serviced again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_i | input | NUM_SRC | Hardware error strobes, one per source |
| sw_req_i | input | 1 | Software trap request strobe |
| sw_num_i | input | TN_W | Trap number of the software request |
| svc_ret_i | input | 1 | Return-from-service strobe |
| flag_wr_i | input | 1 | Flag register write enable |
| flag_wdata_i | input | NUM_SRC | Write data; 0 bits clear flags |
| take_o | output | 1 | One-cycle take-trap pulse |
| vec_o | output | TN_W+2 | Vector of the latest take (trap number * 4) |
| irq_inhibit_o | output | 1 | Blocks ordinary and transfer interrupts |
| flags_o | output | NUM_SRC | Trap flag register |

## Verification
The properties assume that `svc_ret_i` is pulsed only while a service is active and for one cycle per service. They also assume that error and request inputs are single-cycle strobes. The stimulus is driven on falling edges and issues exactly one return per take it expects, always after that take has appeared. Flag writes are applied only in cycles where the bench predicts the flag contents, so the property that flags are never cleared without a write stays meaningful.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SOFT = 2'd1,
        ST_HW   = 2'd2
    } trap_state_e;

    // Fixed class of a hardware source: low indices rank highest.
    function automatic int unsigned class_of(input int unsigned idx,
                                             input int unsigned nsrc,
                                             input int unsigned ncls);
        return ncls - 1 - (idx * ncls) / nsrc;
    endfunction

endpackage

// File: rtl/trap_flag_bank.sv
module trap_flag_bank #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] err_i,
    input  logic               flag_wr_i,
    input  logic [NUM_SRC-1:0] flag_wdata_i,
    input  logic [NUM_SRC-1:0] taken_oh_i,
    output logic [NUM_SRC-1:0] flags_o,
    output logic [NUM_SRC-1:0] pend_o
);

    logic [NUM_SRC-1:0] flags_q;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] keep_mask;

    always_comb keep_mask = flag_wr_i ? flag_wdata_i : '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            pend_q  <= '0;
        end else begin
            // New strobes win over both software clears and takes.
            flags_q <= (flags_q & keep_mask) | err_i;
            pend_q  <= (pend_q & ~taken_oh_i) | err_i;
        end
    end

    assign flags_o = flags_q;
    assign pend_o  = pend_q;

endmodule

// File: rtl/trap_picker.sv
module trap_picker #(
    parameter int NUM_SRC = 8,
    parameter int NUM_CLS = 3,
    parameter int IDX_W   = $clog2(NUM_SRC),
    parameter int CLS_W   = $clog2(NUM_CLS + 1)
) (
    input  logic [NUM_SRC-1:0] pend_i,
    output logic               valid_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic [CLS_W-1:0]   cls_o
);

    logic [CLS_W-1:0] cls_tab [NUM_SRC];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cls
        assign cls_tab[g] = CLS_W'(trap_pkg::class_of(g, NUM_SRC, NUM_CLS));
    end

    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        cls_o   = '0;
        for (int k = NUM_SRC - 1; k >= 0; k--) begin
            if (pend_i[k]) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(k);
                cls_o   = cls_tab[k];
            end
        end
    end

endmodule

// File: rtl/trap_level_stack.sv
module trap_level_stack #(
    parameter int NUM_LVL = 4,
    parameter int LVL_W   = $clog2(NUM_LVL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_i,
    input  logic [LVL_W-1:0]   push_lvl_i,
    input  logic               pop_i,
    output logic [NUM_LVL-1:0] active_o,
    output logic [NUM_LVL-1:0] active_nx_o
);

    logic [NUM_LVL-1:0] active_q;
    logic [NUM_LVL-1:0] popped;

    // Clear the highest set bit (innermost service).
    always_comb begin
        popped = active_q;
        for (int k = 0; k < NUM_LVL; k++) begin
            if (active_q[k]) begin
                popped = active_q & ~(NUM_LVL'(1) << k);
            end
        end
    end

    always_comb begin
        active_nx_o = active_q;
        if (pop_i) begin
            active_nx_o = popped;
        end else if (push_i) begin
            active_nx_o = active_q | (NUM_LVL'(1) << push_lvl_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) active_q <= '0;
        else        active_q <= active_nx_o;
    end

    assign active_o = active_q;

endmodule

// File: rtl/trap_unit.sv
module trap_unit #(
    parameter int NUM_SRC = 8,
    parameter int NUM_CLS = 3,
    parameter int TN_W    = 7,
    parameter int HW_BASE = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] err_i,
    input  logic               sw_req_i,
    input  logic [TN_W-1:0]    sw_num_i,
    input  logic               svc_ret_i,
    input  logic               flag_wr_i,
    input  logic [NUM_SRC-1:0] flag_wdata_i,
    output logic               take_o,
    output logic [TN_W+1:0]    vec_o,
    output logic               irq_inhibit_o,
    output logic [NUM_SRC-1:0] flags_o
);
    import trap_pkg::*;

    localparam int IDX_W   = $clog2(NUM_SRC);
    localparam int CLS_W   = $clog2(NUM_CLS + 1);
    localparam int NUM_LVL = NUM_CLS + 1;
    localparam int LVL_W   = $clog2(NUM_LVL);
    localparam int VEC_W   = TN_W + 2;

    trap_state_e        state_q, state_d;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] taken_oh;
    logic               pick_valid;
    logic [IDX_W-1:0]   pick_idx;
    logic [CLS_W-1:0]   pick_cls;
    logic [NUM_LVL-1:0] active, active_nx;
    logic               sw_pend_q;
    logic [TN_W-1:0]    sw_num_q;
    logic               take_hw, take_sw, pop;
    logic [LVL_W-1:0]   push_lvl;
    logic [TN_W-1:0]    take_num;
    logic               take_q;
    logic [VEC_W-1:0]   vec_q;

    trap_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .err_i        (err_i),
        .flag_wr_i    (flag_wr_i),
        .flag_wdata_i (flag_wdata_i),
        .taken_oh_i   (taken_oh),
        .flags_o      (flags_o),
        .pend_o       (pend)
    );

    trap_picker #(
        .NUM_SRC (NUM_SRC),
        .NUM_CLS (NUM_CLS),
        .IDX_W   (IDX_W),
        .CLS_W   (CLS_W)
    ) u_pick (
        .pend_i  (pend),
        .valid_o (pick_valid),
        .idx_o   (pick_idx),
        .cls_o   (pick_cls)
    );

    trap_level_stack #(
        .NUM_LVL (NUM_LVL),
        .LVL_W   (LVL_W)
    ) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (take_hw | take_sw),
        .push_lvl_i  (push_lvl),
        .pop_i       (pop),
        .active_o    (active),
        .active_nx_o (active_nx)
    );

    // Take decisions: a hardware trap must outrank every active level.
    always_comb begin
        take_hw = pick_valid && !svc_ret_i &&
                  ((active >> (32'(pick_cls) + 32'd1)) == '0);
        take_sw = sw_pend_q && !pick_valid && !svc_ret_i && (active == '0);
        pop     = svc_ret_i && (active != '0);
        push_lvl = take_hw ? LVL_W'(32'(pick_cls) + 32'd1) : '0;
        take_num = take_hw ? TN_W'(HW_BASE) + TN_W'(pick_idx) : sw_num_q;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_oh
        assign taken_oh[g] = take_hw && (pick_idx == IDX_W'(g));
    end

    // One-deep software request slot.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_pend_q <= 1'b0;
            sw_num_q  <= '0;
        end else if (take_sw) begin
            sw_pend_q <= 1'b0;
        end else if (sw_req_i && !sw_pend_q) begin
            sw_pend_q <= 1'b1;
            sw_num_q  <= sw_num_i;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_hw)      state_d = ST_HW;
                else if (take_sw) state_d = ST_SOFT;
            end
            ST_SOFT: begin
                if (pop)          state_d = ST_IDLE;
                else if (take_hw) state_d = ST_HW;
            end
            ST_HW: begin
                if (pop) begin
                    if (active_nx[NUM_LVL-1:1] != '0) state_d = ST_HW;
                    else if (active_nx[0])            state_d = ST_SOFT;
                    else                              state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            take_q <= 1'b0;
            vec_q  <= '0;
        end else begin
            take_q <= take_hw | take_sw;
            if (take_hw | take_sw) vec_q <= {take_num, 2'b00};
        end
    end

    assign take_o        = take_q;
    assign vec_o         = vec_q;
    assign irq_inhibit_o = (state_q == ST_HW);

endmodule

// File: rtl/trap_unit_chk.sv
module trap_unit_chk #(
    parameter int NUM_SRC = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] err_i,
    input logic               svc_ret_i,
    input logic               flag_wr_i,
    input logic               take_o,
    input logic               irq_inhibit_o,
    input logic [NUM_SRC-1:0] flags_o
);

    // R2
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_i != '0) |=> ((flags_o & $past(err_i)) == $past(err_i)));

    // R3
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_wr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

    // R7
    inhibit_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_inhibit_o) |-> take_o);

    // R7
    inhibit_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_inhibit_o) |-> $past(svc_ret_i));

    // R9
    no_take_on_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !$past(svc_ret_i));

endmodule

bind trap_unit trap_unit_chk #(.NUM_SRC(NUM_SRC)) u_trap_unit_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .err_i         (err_i),
    .svc_ret_i     (svc_ret_i),
    .flag_wr_i     (flag_wr_i),
    .take_o        (take_o),
    .irq_inhibit_o (irq_inhibit_o),
    .flags_o       (flags_o)
);

// File: tb/trap_unit_bench.sv
module trap_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 8;
    localparam int TNW  = 7;
    localparam int WATCHDOG = 20000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] err_i = '0;
    logic            sw_req_i = 1'b0;
    logic [TNW-1:0]  sw_num_i = '0;
    logic            svc_ret_i = 1'b0;
    logic            flag_wr_i = 1'b0;
    logic [NSRC-1:0] flag_wdata_i = '0;
    logic            take_o;
    logic [TNW+1:0]  vec_o;
    logic            irq_inhibit_o;
    logic [NSRC-1:0] flags_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [TNW+1:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_unit u_trap_unit (
        .clk           (clk),
        .rst_n         (rst_n),
        .err_i         (err_i),
        .sw_req_i      (sw_req_i),
        .sw_num_i      (sw_num_i),
        .svc_ret_i     (svc_ret_i),
        .flag_wr_i     (flag_wr_i),
        .flag_wdata_i  (flag_wdata_i),
        .take_o        (take_o),
        .vec_o         (vec_o),
        .irq_inhibit_o (irq_inhibit_o),
        .flags_o       (flags_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hw_pulse(input logic [NSRC-1:0] m);
        err_i = m;
        tick(1);
        err_i = '0;
    endtask

    task automatic ret_pulse();
        svc_ret_i = 1'b1;
        tick(1);
        svc_ret_i = 1'b0;
    endtask

    task automatic sw_pulse(input logic [TNW-1:0] n);
        sw_req_i = 1'b1;
        sw_num_i = n;
        tick(1);
        sw_req_i = 1'b0;
    endtask

    task automatic expect_take(input int num);
        exp_q.push_back((TNW+2)'(num * 4));
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Monitor: every take pulse is matched against the scoreboard queue (R4, R5, R6, R8).
    always @(negedge clk) begin
        if (rst_n && take_o) begin
            if (exp_q.size() == 0) begin
                check("R6 unexpected take", 32'(vec_o), 32'hFFFF);
            end else begin
                check("R4/R5 take vector", 32'(vec_o), 32'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        tick(3);
        // R1 reset state
        check("R1 flags", 32'(flags_o), 0);
        check("R1 take", 32'(take_o), 0);
        check("R1 vec", 32'(vec_o), 0);
        check("R1 inhibit", 32'(irq_inhibit_o), 0);
        rst_n = 1'b1;
        tick(2);

        // R2/R4: source 4 (class 1)
        expect_take((2 + 4));
        hw_pulse(8'h10);
        tick(2);
        check("R2 flag set", 32'(flags_o), 32'h10);
        check("R7 inhibit on take", 32'(irq_inhibit_o), 1);

        // R6: same class waits, higher class preempts
        hw_pulse(8'h20);
        tick(4);
        expect_take(2 + 0);
        hw_pulse(8'h01);
        tick(3);
        ret_pulse();
        tick(3);
        check("R9 inhibit after inner return", 32'(irq_inhibit_o), 1);
        expect_take(2 + 5);
        ret_pulse();
        tick(4);
        check("R7 inhibit for waiting trap", 32'(irq_inhibit_o), 1);
        ret_pulse();
        tick(2);
        check("R7 inhibit after outer return", 32'(irq_inhibit_o), 0);

        // R5: simultaneous sources 1 and 3 -> 1 first
        expect_take(2 + 1);
        expect_take(2 + 3);
        hw_pulse(8'h0A);
        tick(3);
        ret_pulse();
        tick(3);
        ret_pulse();
        tick(2);
        // R5: two class-0 sources, lower index first
        expect_take(2 + 6);
        expect_take(2 + 7);
        hw_pulse(8'hC0);
        tick(3);
        ret_pulse();
        tick(3);
        ret_pulse();
        tick(2);
        check("R2 accumulated flags", 32'(flags_o), 32'hFB);

        // R3: clearing writes
        flag_wr_i = 1'b1;
        flag_wdata_i = 8'h0F;
        tick(1);
        flag_wr_i = 1'b0;
        tick(1);
        check("R3 partial clear", 32'(flags_o), 32'h0B);
        expect_take(2 + 0);
        flag_wr_i = 1'b1;
        flag_wdata_i = 8'h00;
        err_i = 8'h01;
        tick(1);
        flag_wr_i = 1'b0;
        err_i = '0;
        tick(1);
        check("R3 strobe beats clear", 32'(flags_o), 32'h01);
        tick(1);
        ret_pulse();
        tick(2);

        // R10: repeat strobe on set flag
        expect_take(2 + 0);
        hw_pulse(8'h01);
        tick(2);
        check("R10 retaken inhibit", 32'(irq_inhibit_o), 1);
        ret_pulse();
        tick(2);

        // R8: software trap
        expect_take(32);
        sw_pulse(7'h20);
        tick(2);
        check("R8 no inhibit on software trap", 32'(irq_inhibit_o), 0);
        expect_take(2 + 7);
        hw_pulse(8'h80);
        tick(2);
        check("R6 hw preempts software", 32'(irq_inhibit_o), 1);
        ret_pulse();
        tick(2);
        check("R7 back to software level", 32'(irq_inhibit_o), 0);
        expect_take(5);
        sw_pulse(7'd5);
        tick(2);
        sw_pulse(7'd6);
        tick(2);
        ret_pulse();
        tick(4);
        ret_pulse();
        tick(6);
        check("R8 second request ignored", 32'(exp_q.size()), 0);
        check("R8 inhibit idle", 32'(irq_inhibit_o), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule